// File: doc/BRIEF.md
# Banked Chip-Select Address Decoder

This block maps a 32-bit bus address onto one of a set of memory banks (eight by default). Each bank has a programmable base word and a mask word. A bank takes part only when it is enabled. It claims an address when the address and the base agree in every bit the mask keeps. Decoding works on 32 KB regions. For each accepted request the block returns a one-hot chip-select, the winning bank's data-width code and its access-engine code, and two error indications. It does not build the external bus cycle, run any timing engine or handle ECC.

Requests enter over a valid/ready handshake. Results leave through a one-deep output register that also uses valid/ready. The input is ready whenever the output register is empty or is being drained in the same cycle. A stalled result holds all of its fields unchanged until the consumer takes it. Configuration and error status sit on a plain write/read port. The read data is combinational. A bank's base word is at address 2*i and its mask word at 2*i+1. The error status word is at address 2*NBANK.

Top module: `chipsel_decoder`

## Requirements
- R1: After reset every bank is disabled, every configuration word and the status word read 0, rsp_valid is 0 and req_ready is 1.
- R2: A base word keeps only bits 31:15 (region base), 12:11 (width code), 8 (protect), 7:5 (engine code) and 0 (enable), and every other bit reads back 0. A mask word keeps only bits 31:15, and its lower bits read back 0.
- R3: A bank claims an address when its bit 0 is 1 and ((address XOR base) AND mask) is zero over bits 31:15. A bank with bit 0 clear never claims.
- R4: When several banks claim an address, the lowest-numbered one wins, and rsp_cs never has more than one bit set.
- R5: For a winning bank, rsp_psize returns base bits 12:11 (01 = 8-bit, 10 = 16-bit, 11 = 32-bit) and rsp_msel returns base bits 7:5 (000 general-purpose, 001 flash, 011 SDRAM, 100/101/110 user machines A/B/C).
- R6: An access that no bank claims returns rsp_cs = 0 with rsp_cs_err = 1, and sets status bit 0 (no-match flag).
- R7: A write whose winning bank has base bit 8 set is blocked. It returns rsp_cs = 0 with rsp_wp_err = 1 and sets status bit 1 (protect flag). A read of that bank decodes normally.
- R8: Status flags are sticky. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A flag being set in the same cycle as a clear stays set.
- R9: req_ready equals !rsp_valid || rsp_ready. While rsp_valid is 1 and rsp_ready is 0, every response field stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | RA (5) | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request ready |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write access |
| rsp_valid | output | 1 | Decode result valid |
| rsp_ready | input | 1 | Decode result accepted |
| rsp_cs | output | NBANK (8) | One-hot chip-select |
| rsp_psize | output | 2 | Width code of the winning bank |
| rsp_msel | output | 3 | Engine code of the winning bank |
| rsp_cs_err | output | 1 | No bank claimed the access |
| rsp_wp_err | output | 1 | Write to a protected bank was blocked |
| err_sticky | output | 2 | Sticky flags: bit 0 no-match, bit 1 protect |

## Verification
The decode is driven with addresses at several points:
- inside a wide-mask region and just past its end, which separates masked from unmasked compare bits;
- against a programmed but disabled bank, which shows the enable bit is obeyed;
- into two overlapping enabled banks, at an address both claim and at one only the wider claims, which exposes the priority order;
- through banks that each carry a different width and engine code, which catches swapped fields.

Protected banks are hit with both a read and a write. Status clears are tried with 0, with 1, and at the same time as a fresh error. The output is stalled while a second request waits, to show that results are held and the input is back-pressured.

// File: rtl/chipsel_pkg.sv
package chipsel_pkg;
  localparam int DW      = 32;
  localparam int REG_LSB = 15;

  // base word field positions
  localparam int EN_BIT  = 0;
  localparam int WP_BIT  = 8;
  localparam int MS_LSB  = 5;
  localparam int PS_LSB  = 11;

  localparam logic [DW-1:0] BASE_KEEP = 32'hFFFF_99E1;
  localparam logic [DW-1:0] MASK_KEEP = 32'hFFFF_8000;

  typedef struct packed {
    logic [1:0] psize;
    logic [2:0] msel;
    logic       wp;
  } bank_attr_t;

  function automatic bank_attr_t attr_of(input logic [DW-1:0] b);
    bank_attr_t a;
    a.psize = b[PS_LSB+1:PS_LSB];
    a.msel  = b[MS_LSB+2:MS_LSB];
    a.wp    = b[WP_BIT];
    return a;
  endfunction
endpackage

// File: rtl/chipsel_bank_regs.sv
module chipsel_bank_regs
  import chipsel_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int RA    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RA-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   base_q [NBANK],
  output logic [DW-1:0]   mask_q [NBANK],
  output logic [DW-1:0]   rdata,
  output logic            rhit
);
  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    localparam logic [RA-1:0] A_BASE = RA'(2*i);
    localparam logic [RA-1:0] A_MASK = RA'(2*i+1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
      end else if (we) begin
        if (addr == A_BASE) base_q[i] <= wdata & BASE_KEEP;
        if (addr == A_MASK) mask_q[i] <= wdata & MASK_KEEP;
      end
    end
  end

  always_comb begin
    rdata = '0;
    rhit  = 1'b0;
    for (int i = 0; i < NBANK; i++) begin
      if (addr == RA'(2*i))   begin rdata = base_q[i]; rhit = 1'b1; end
      if (addr == RA'(2*i+1)) begin rdata = mask_q[i]; rhit = 1'b1; end
    end
  end
endmodule

// File: rtl/chipsel_bank_match.sv
module chipsel_bank_match
  import chipsel_pkg::*;
#(
  parameter int NBANK = 8
) (
  input  logic [DW-1:0]   addr,
  input  logic [DW-1:0]   base_q [NBANK],
  input  logic [DW-1:0]   mask_q [NBANK],
  output logic [NBANK-1:0] hit
);
  // mask words hold zero below REG_LSB, so the full-width compare is
  // equivalent to comparing the region bits only
  for (genvar i = 0; i < NBANK; i++) begin : g_cmp
    assign hit[i] = base_q[i][EN_BIT] &&
                    (((addr ^ base_q[i]) & mask_q[i]) == '0);
  end
endmodule

// File: rtl/chipsel_prio_pick.sv
module chipsel_prio_pick #(
  parameter int NBANK = 8
) (
  input  logic [NBANK-1:0] hit,
  output logic [NBANK-1:0] grant,
  output logic             any
);
  always_comb begin
    grant = '0;
    for (int i = NBANK-1; i >= 0; i--) begin
      if (hit[i]) grant = NBANK'(1) << i;
    end
  end
  assign any = |hit;
endmodule

// File: rtl/chipsel_decoder.sv
module chipsel_decoder
  import chipsel_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int RA    = $clog2(2*NBANK+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [RA-1:0]    cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_addr,
  input  logic             req_write,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [NBANK-1:0] rsp_cs,
  output logic [1:0]       rsp_psize,
  output logic [2:0]       rsp_msel,
  output logic             rsp_cs_err,
  output logic             rsp_wp_err,
  output logic [1:0]       err_sticky
);
  localparam logic [RA-1:0] A_STAT = RA'(2*NBANK);

  logic [DW-1:0]    base_q [NBANK];
  logic [DW-1:0]    mask_q [NBANK];
  logic [DW-1:0]    bank_rdata;
  logic             bank_rhit;
  logic [NBANK-1:0] hit, grant;
  logic             any_hit;
  bank_attr_t       sel_attr;
  logic             wp_block, accept;
  logic [1:0]       err_set, err_clr;

  chipsel_bank_regs #(.NBANK(NBANK), .RA(RA)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .base_q(base_q), .mask_q(mask_q),
    .rdata(bank_rdata), .rhit(bank_rhit)
  );

  chipsel_bank_match #(.NBANK(NBANK)) u_match (
    .addr(req_addr), .base_q(base_q), .mask_q(mask_q), .hit(hit)
  );

  chipsel_prio_pick #(.NBANK(NBANK)) u_pick (
    .hit(hit), .grant(grant), .any(any_hit)
  );

  always_comb begin
    sel_attr = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (grant[i]) sel_attr = sel_attr | attr_of(base_q[i]);
    end
  end

  assign wp_block  = any_hit && req_write && sel_attr.wp;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_cs     <= '0;
      rsp_psize  <= '0;
      rsp_msel   <= '0;
      rsp_cs_err <= 1'b0;
      rsp_wp_err <= 1'b0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_cs     <= wp_block ? '0 : grant;
      rsp_psize  <= sel_attr.psize;
      rsp_msel   <= sel_attr.msel;
      rsp_cs_err <= !any_hit;
      rsp_wp_err <= wp_block;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  assign err_set = accept ? {wp_block, !any_hit} : 2'b00;
  assign err_clr = (cfg_we && cfg_addr == A_STAT) ? cfg_wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_sticky <= '0;
    else        err_sticky <= (err_sticky & ~err_clr) | err_set;
  end

  always_comb begin
    if (bank_rhit)              cfg_rdata = bank_rdata;
    else if (cfg_addr == A_STAT) cfg_rdata = {30'd0, err_sticky};
    else                        cfg_rdata = '0;
  end
endmodule

// File: rtl/chipsel_decoder_chk.sv
module chipsel_decoder_chk #(
  parameter int NBANK = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [NBANK-1:0] rsp_cs,
  input logic [1:0]       rsp_psize,
  input logic [2:0]       rsp_msel,
  input logic             rsp_cs_err,
  input logic             rsp_wp_err,
  input logic [1:0]       err_sticky
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(rsp_cs)); // R4

  AST_ERR_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_cs_err || rsp_wp_err)) |-> (rsp_cs == '0)); // R6

  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_cs_err && rsp_wp_err)); // R7

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_cs) &&
      $stable(rsp_psize) && $stable(rsp_msel) && $stable(rsp_cs_err) &&
      $stable(rsp_wp_err))); // R9

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R9

  AST_FLAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && rsp_cs_err) |-> err_sticky[0]); // R6
endmodule

bind chipsel_decoder chipsel_decoder_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_cs(rsp_cs), .rsp_psize(rsp_psize),
  .rsp_msel(rsp_msel), .rsp_cs_err(rsp_cs_err), .rsp_wp_err(rsp_wp_err),
  .err_sticky(err_sticky)
);

// File: tb/chipsel_decoder_tb.sv
module chipsel_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int RA = 5;
  localparam logic [RA-1:0] STAT = 5'd16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [RA-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [31:0] req_addr = '0;
  logic rsp_valid, rsp_ready = 1;
  logic [NB-1:0] rsp_cs;
  logic [1:0] rsp_psize, err_sticky;
  logic [2:0] rsp_msel;
  logic rsp_cs_err, rsp_wp_err;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chipsel_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_cs(rsp_cs),
    .rsp_psize(rsp_psize), .rsp_msel(rsp_msel), .rsp_cs_err(rsp_cs_err),
    .rsp_wp_err(rsp_wp_err), .err_sticky(err_sticky)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [RA-1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_rd(input logic [RA-1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  // one accepted request; response sampled at the following negedge
  task automatic access(input logic [31:0] a, input logic wr);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = wr;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 req_ready", 32'(req_ready), 1);
    cfg_rd(5'd0, d);  chk("R1 base0", d, 0);
    cfg_rd(5'd15, d); chk("R1 mask7", d, 0);
    cfg_rd(STAT, d);  chk("R1 status", d, 0);
    access(32'h0000_0000, 0);
    chk("R1 no bank enabled", 32'(rsp_cs_err), 1);
    cfg_wr(STAT, 32'h3);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    cfg_wr(5'd14, 32'hFFFF_FFFF);
    cfg_rd(5'd14, d); chk("R2 base reserved bits", d, 32'hFFFF_99E1);
    cfg_wr(5'd15, 32'hFFFF_FFFF);
    cfg_rd(5'd15, d); chk("R2 mask low bits", d, 32'hFFFF_8000);
    cfg_wr(5'd14, 32'h0);
    cfg_wr(5'd15, 32'h0);
  endtask

  task automatic t_match();
    // bank0: 0x1000_0000, 64KB, 32-bit, SDRAM
    cfg_wr(5'd0, 32'h1000_0000 | (3 << 11) | (3 << 5) | 1);
    cfg_wr(5'd1, 32'hFFFF_0000);
    access(32'h1000_8004, 0);
    chk("R3 inside region cs", 32'(rsp_cs), 32'h01);
    chk("R5 psize 32-bit", 32'(rsp_psize), 3);
    chk("R5 msel SDRAM", 32'(rsp_msel), 3);
    access(32'h1001_0000, 0);
    chk("R6 past region cs", 32'(rsp_cs), 0);
    chk("R6 cs_err", 32'(rsp_cs_err), 1);
    chk("R6 sticky bit0", 32'(err_sticky), 1);
    // bank1 programmed but disabled
    cfg_wr(5'd2, 32'h2000_0000);
    cfg_wr(5'd3, 32'hF000_0000);
    access(32'h2000_0000, 0);
    chk("R3 disabled bank ignored", 32'(rsp_cs_err), 1);
  endtask

  task automatic t_prio();
    cfg_wr(5'd4, 32'h4000_0000 | (1 << 11) | (1 << 5) | 1);
    cfg_wr(5'd5, 32'hF000_0000);
    cfg_wr(5'd6, 32'h4000_0000 | 1);
    cfg_wr(5'd7, 32'hFFFF_8000);
    access(32'h4000_0000, 0);
    chk("R4 lowest bank wins", 32'(rsp_cs), 32'h04);
    chk("R5 psize 8-bit", 32'(rsp_psize), 1);
    chk("R5 msel flash", 32'(rsp_msel), 1);
    access(32'h4100_0000, 0);
    chk("R4 wide bank only", 32'(rsp_cs), 32'h04);
    cfg_wr(5'd8, 32'h5000_0000 | (2 << 11) | (4 << 5) | 1);
    cfg_wr(5'd9, 32'hF000_0000);
    access(32'h5123_4567, 0);
    chk("R5 bank4 cs", 32'(rsp_cs), 32'h10);
    chk("R5 psize 16-bit", 32'(rsp_psize), 2);
    chk("R5 msel user A", 32'(rsp_msel), 4);
  endtask

  task automatic t_wp();
    logic [31:0] d;
    cfg_wr(STAT, 32'h3);
    cfg_wr(5'd10, 32'h6000_0000 | (1 << 11) | (1 << 8) | 1);
    cfg_wr(5'd11, 32'hF000_0000);
    access(32'h6000_0010, 1);
    chk("R7 write blocked cs", 32'(rsp_cs), 0);
    chk("R7 wp_err", 32'(rsp_wp_err), 1);
    chk("R7 sticky bit1", 32'(err_sticky), 2);
    access(32'h6000_0010, 0);
    chk("R7 read passes", 32'(rsp_cs), 32'h20);
    chk("R7 read no wp_err", 32'(rsp_wp_err), 0);
    access(32'h7000_0000, 0);
    cfg_rd(STAT, d); chk("R8 both flags", d, 3);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    cfg_wr(STAT, 32'h0);
    cfg_rd(STAT, d); chk("R8 write 0 keeps", d, 3);
    cfg_wr(STAT, 32'h1);
    cfg_rd(STAT, d); chk("R8 clear bit0", d, 2);
    cfg_wr(STAT, 32'h2);
    cfg_rd(STAT, d); chk("R8 clear bit1", d, 0);
    @(negedge clk);
    cfg_we = 1; cfg_addr = STAT; cfg_wdata = 32'h1;
    req_valid = 1; req_addr = 32'h7000_0000; req_write = 0;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    chk("R8 set wins over clear", 32'(err_sticky), 1);
  endtask

  task automatic t_stall();
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_addr = 32'h1000_0000; req_write = 0;
    @(negedge clk);
    req_addr = 32'h6000_0000;
    chk("R9 first result cs", 32'(rsp_cs), 32'h01);
    chk("R9 input blocked", 32'(req_ready), 0);
    @(negedge clk);
    chk("R9 held valid", 32'(rsp_valid), 1);
    chk("R9 held cs", 32'(rsp_cs), 32'h01);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R9 second result cs", 32'(rsp_cs), 32'h20);
    @(negedge clk);
    chk("R9 drained", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_match();
    t_prio();
    t_wp();
    t_w1c();
    t_stall();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule